// File: doc/BRIEF.md
# Scan-Line Interval Capture Encoder

This block times the gaps between successive edge pulses on one video scan line. A line is 512 clock ticks long, so each gap fits in a 9-bit word. A bank of 32 interval counters is armed by the line-start sync. Counter 0 runs first. Each edge pulse freezes the running counter and hands counting to the next one. The last counter that was started keeps running until end-of-line.

At end-of-line the whole counter bank is copied in a single cycle into a holding bank. The held words then go out as a stream, one word per slot, with a slot index beside each word. The number of words per line, N, is sampled at end-of-line. The spacing between slots is one line length divided by N. While the held words stream out, the counters are already timing the next line, so the two lines never interfere.

The output is a valid/ready stream. A word that has been offered stays on the port, with the same index, until the cycle in which ready is high. Back-pressure delays the words but never drops one. If a slot time passes during a stall, the next word follows in the cycle straight after the stalled word is accepted.

Top module: `scanline_interval_enc`

## Requirements
- R1: After reset, `out_valid` and `ovf` are low.
- R2: Counter k reports the number of rising clock edges from the edge that sampled its start marker to the edge that sampled the edge pulse that stopped it. The start marker of counter 0 is `line_start`; for any other counter it is the previous edge pulse.
- R3: A counter that reaches 511 holds at 511 and does not wrap.
- R4: Once 32 edge pulses have been taken in a line, any further edge pulse changes no counter and sets `ovf`. `ovf` stays high until the next `line_start`, which clears it.
- R5: On `line_end`, every counter value from before that edge is copied to the holding bank. The counter still running at that point reports its count up to the cycle before `line_end`. Counters that were never started report 0.
- R6: In the cycle after `line_end` is sampled, slot 0 is offered. Slots then follow in ascending order, and exactly N words are sent per line.
- R7: With `out_ready` held high, consecutive words start 512/N cycles apart when N divides 512. In general, N words are spread evenly over each 512 cycles.
- R8: `n_slots` is sampled only on `line_end`. A value of 0 is treated as 1, and a value above 32 is treated as 32.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` and `out_slot` hold their values. If a slot time falls inside the stall, the next word is offered in the cycle right after the stalled word is accepted.
- R10: Capture of the following line, including a change of `n_slots`, does not alter the words, order or spacing of the readout in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Position clock, one tick per line position |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Line sync: clears and arms the counter bank |
| edge_pulse | input | 1 | Edge marker: stops the running counter and starts the next |
| line_end | input | 1 | End of line: copies the counters and starts readout |
| n_slots | input | 6 | Words to send per line, clamped to the range 1 to 32 |
| out_ready | input | 1 | Downstream ready for the output stream |
| out_valid | output | 1 | An interval word is being offered |
| out_word | output | 9 | Interval length in ticks |
| out_slot | output | 5 | Index of the interval being offered |
| ovf | output | 1 | Sticky flag: more edges arrived than there are counters |

## Verification
Four things are checked on every cycle. A stalled word and its index stay stable. Slot 0 appears right after end-of-line. The index steps by one on back-to-back handoffs. The overflow flag rises only after an edge pulse and drops after line sync. The bench scenarios are needed to show the measured interval values, saturation, the copy of the running and unused counters, the slot spacing for several N, the clamping of N, and that a readout survives the next line being captured beneath it.

// File: rtl/sli_pkg.sv
`timescale 1ns/1ps
package sli_pkg;
  localparam int unsigned SLI_INTERVALS = 32;
  localparam int unsigned SLI_TICK_BITS = 9;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/sli_capture.sv
`timescale 1ns/1ps
module sli_capture #(
  parameter int unsigned NUM   = 32,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_start,
  input  logic                      edge_pulse,
  input  logic                      line_end,
  output logic [NUM-1:0][CNT_W-1:0] cnt_bank,
  output logic                      ovf
);
  import sli_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cap_state_e         state_q;
  logic [IDX_W-1:0]   act_q;
  logic               taking;
  logic               full;

  assign full   = (act_q == IDX_W'(NUM));
  assign taking = (state_q == CAP_RUN) && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      act_q   <= '0;
      ovf     <= 1'b0;
    end else if (line_start) begin
      state_q <= CAP_RUN;
      act_q   <= '0;
      ovf     <= 1'b0;
    end else begin
      if (line_end) state_q <= CAP_IDLE;
      if (state_q == CAP_RUN && edge_pulse) begin
        if (full) ovf   <= 1'b1;
        else      act_q <= act_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || line_start) begin
        cnt_bank[i] <= '0;
      end else if (taking && act_q == IDX_W'(i) && cnt_bank[i] != CNT_MAX) begin
        cnt_bank[i] <= cnt_bank[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sli_pacer.sv
`timescale 1ns/1ps
module sli_pacer #(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] n_step,
  output logic             tick
);
  localparam int unsigned ACC_W      = CNT_W + 1;
  localparam int unsigned LINE_TICKS = 1 << CNT_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum  = acc_q + ACC_W'(n_step);
  assign tick = (sum >= ACC_W'(LINE_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) acc_q <= '0;
    else if (tick)         acc_q <= sum - ACC_W'(LINE_TICKS);
    else                   acc_q <= sum;
  end
endmodule

// File: rtl/sli_readout.sv
`timescale 1ns/1ps
module sli_readout #(
  parameter int unsigned NUM    = 32,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned SLOT_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_end,
  input  logic [NUM-1:0][CNT_W-1:0] cnt_bank,
  input  logic [IDX_W-1:0]          n_req,
  input  logic                      tick,
  input  logic                      out_ready,
  output logic [IDX_W-1:0]          n_eff,
  output logic                      out_valid,
  output logic [CNT_W-1:0]          out_word,
  output logic [SLOT_W-1:0]         out_slot
);
  logic [NUM-1:0][CNT_W-1:0] hold_q;
  logic [IDX_W-1:0]          n_clamp;
  logic [IDX_W-1:0]          next_q;
  logic                      owed_q;
  logic                      accept, more, want;

  always_comb begin
    if (n_req == '0)                n_clamp = IDX_W'(1);
    else if (n_req > IDX_W'(NUM))   n_clamp = IDX_W'(NUM);
    else                            n_clamp = n_req;
  end

  assign accept = out_valid && out_ready;
  assign more   = (next_q < n_eff);
  assign want   = tick || owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      n_eff     <= IDX_W'(1);
      next_q    <= '0;
      owed_q    <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_slot  <= '0;
    end else if (line_end) begin
      hold_q    <= cnt_bank;
      n_eff     <= n_clamp;
      next_q    <= IDX_W'(1);
      owed_q    <= 1'b0;
      out_valid <= 1'b1;
      out_word  <= cnt_bank[0];
      out_slot  <= '0;
    end else begin
      if (accept) out_valid <= 1'b0;
      if (want && more && (!out_valid || accept)) begin
        out_valid <= 1'b1;
        out_word  <= hold_q[next_q[SLOT_W-1:0]];
        out_slot  <= next_q[SLOT_W-1:0];
        next_q    <= next_q + 1'b1;
        owed_q    <= 1'b0;
      end else if (tick && more) begin
        owed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanline_interval_enc.sv
`timescale 1ns/1ps
module scanline_interval_enc #(
  parameter int unsigned NUM_INT = sli_pkg::SLI_INTERVALS,
  parameter int unsigned CNT_W   = sli_pkg::SLI_TICK_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_start,
  input  logic                         edge_pulse,
  input  logic                         line_end,
  input  logic [$clog2(NUM_INT+1)-1:0] n_slots,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [CNT_W-1:0]             out_word,
  output logic [$clog2(NUM_INT)-1:0]   out_slot,
  output logic                         ovf
);
  localparam int unsigned IDX_W  = $clog2(NUM_INT + 1);
  localparam int unsigned SLOT_W = $clog2(NUM_INT);

  logic [NUM_INT-1:0][CNT_W-1:0] cnt_bank;
  logic [IDX_W-1:0]              n_eff;
  logic                          tick;

  sli_capture #(.NUM(NUM_INT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .edge_pulse(edge_pulse),
    .line_end(line_end), .cnt_bank(cnt_bank), .ovf(ovf)
  );

  sli_pacer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .restart(line_end), .n_step(n_eff), .tick(tick)
  );

  sli_readout #(.NUM(NUM_INT), .CNT_W(CNT_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .cnt_bank(cnt_bank),
    .n_req(n_slots), .tick(tick), .out_ready(out_ready), .n_eff(n_eff),
    .out_valid(out_valid), .out_word(out_word), .out_slot(out_slot)
  );
endmodule

// File: rtl/scanline_interval_enc_chk.sv
`timescale 1ns/1ps
module scanline_interval_enc_chk #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              line_end,
  input logic              edge_pulse,
  input logic              out_ready,
  input logic              out_valid,
  input logic [CNT_W-1:0]  out_word,
  input logic [SLOT_W-1:0] out_slot,
  input logic              ovf
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !line_end) |=> (out_valid && $stable(out_word) && $stable(out_slot))); // R9

  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (out_valid && out_slot == '0)); // R6

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !line_end) |=> (!out_valid || out_slot == $past(out_slot) + SLOT_W'(1))); // R6

  AST_OVF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(edge_pulse)); // R4

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !ovf); // R4
endmodule

bind scanline_interval_enc scanline_interval_enc_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
  .edge_pulse(edge_pulse), .out_ready(out_ready), .out_valid(out_valid),
  .out_word(out_word), .out_slot(out_slot), .ovf(ovf)
);

// File: tb/scanline_interval_enc_tb_top.sv
`timescale 1ns/1ps
module scanline_interval_enc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       edge_pulse = 1'b0;
  logic       line_end = 1'b0;
  logic [5:0] n_slots = 6'd4;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [8:0] out_word;
  logic [4:0] out_slot;
  logic       ovf;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int rec_n = 0;
  int rec_word [64];
  int rec_slot [64];
  int rec_cyc  [64];
  int exp_w    [64];

  scanline_interval_enc dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .edge_pulse(edge_pulse),
    .line_end(line_end), .n_slots(n_slots), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .out_slot(out_slot), .ovf(ovf)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rec_n < 64) begin
      rec_word[rec_n] = int'(out_word);
      rec_slot[rec_n] = int'(out_slot);
      rec_cyc[rec_n]  = cyc;
      rec_n++;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 0);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // kind: 0 line_start, 1 edge_pulse, 2 line_end; sampled gap cycles after the previous pulse
  task automatic strobe(input int gap, input int kind, output int at);
    idle(gap - 1);
    case (kind)
      0: line_start = 1'b1;
      1: edge_pulse = 1'b1;
      default: line_end = 1'b1;
    endcase
    @(posedge clk); #1;
    at = cyc;
    line_start = 1'b0; edge_pulse = 1'b0; line_end = 1'b0;
  endtask

  task automatic check_readout(input string wreq, input int n, input int e_cyc, input int step);
    chk("R6 word count", rec_n, n);
    for (int i = 0; i < n && i < rec_n; i++) begin
      chk(wreq, rec_word[i], exp_w[i]);
      chk("R6 slot order", rec_slot[i], i);
      if (i == 0) chk("R6 first slot cycle", rec_cyc[0], e_cyc);
      else if (step > 0) chk("R7 slot spacing", rec_cyc[i] - rec_cyc[i-1], step);
    end
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 ovf after reset", int'(ovf), 0);
  endtask

  // R2, R6, R7, R8, R10: line A read out while line B is captured
  task automatic t_overlap();
    int t;
    int e_a;
    n_slots = 6'd4;
    strobe(1, 0, t);
    strobe(10, 1, t); strobe(25, 1, t); strobe(3, 1, t); strobe(40, 1, t);
    strobe(50, 2, e_a);
    rec_n = 0;
    exp_w[0] = 10; exp_w[1] = 25; exp_w[2] = 3; exp_w[3] = 40;
    strobe(2, 0, t);
    n_slots = 6'd8;
    for (int k = 0; k < 4; k++) strobe(7, 1, t);
    idle(380);
    check_readout("R2 R10 interval line A", 4, e_a, 128);
    rec_n = 0;
    strobe(21, 2, e_a);
    idle(8 * 64 + 20);
    for (int k = 0; k < 4; k++) exp_w[k] = 7;
    exp_w[4] = 400;
    for (int k = 5; k < 8; k++) exp_w[k] = 0;
    check_readout("R5 R8 interval line B", 8, e_a, 64);
  endtask

  // R5: running counter and never-started counters at end of line
  task automatic t_unreached();
    int t;
    int e;
    n_slots = 6'd8;
    strobe(1, 0, t);
    strobe(5, 1, t); strobe(6, 1, t); strobe(7, 1, t);
    rec_n = 0;
    strobe(20, 2, e);
    idle(8 * 64 + 20);
    exp_w[0] = 5; exp_w[1] = 6; exp_w[2] = 7; exp_w[3] = 19;
    for (int k = 4; k < 8; k++) exp_w[k] = 0;
    check_readout("R5 copied interval", 8, e, 64);
  endtask

  // R3 saturation, R8 clamp of zero to one word
  task automatic t_saturate();
    int t;
    int e;
    n_slots = 6'd0;
    strobe(1, 0, t);
    strobe(600, 1, t);
    rec_n = 0;
    strobe(5, 2, e);
    idle(540);
    exp_w[0] = 511;
    check_readout("R3 saturated interval", 1, e, 0);
  endtask

  // R9: stall across a slot time
  task automatic t_stall();
    int t;
    int e;
    n_slots = 6'd2;
    strobe(1, 0, t);
    strobe(30, 1, t); strobe(40, 1, t);
    rec_n = 0;
    out_ready = 1'b0;
    strobe(10, 2, e);
    idle(100);
    chk("R9 valid held", int'(out_valid), 1);
    chk("R9 word held", int'(out_word), 30);
    idle(200);
    chk("R9 word held past slot time", int'(out_word), 30);
    chk("R9 slot held", int'(out_slot), 0);
    out_ready = 1'b1;
    idle(300);
    chk("R9 words delivered", rec_n, 2);
    if (rec_n == 2) begin
      chk("R9 first word", rec_word[0], 30);
      chk("R9 second word", rec_word[1], 40);
      chk("R9 owed word follows accept", rec_cyc[1] - rec_cyc[0], 1);
      chk("R9 accepted at ready", rec_cyc[0], e + 300);
    end
  endtask

  // R4 overflow, R8 clamp above 32
  task automatic t_overflow();
    int t;
    int e;
    n_slots = 6'd40;
    strobe(1, 0, t);
    for (int k = 0; k < 32; k++) strobe(2, 1, t);
    chk("R4 ovf low after 32 edges", int'(ovf), 0);
    strobe(2, 1, t);
    chk("R4 ovf set by extra edge", int'(ovf), 1);
    rec_n = 0;
    strobe(3, 2, e);
    idle(32 * 16 + 20);
    for (int k = 0; k < 32; k++) exp_w[k] = 2;
    check_readout("R4 extra edge ignored", 32, e, 16);
    chk("R4 ovf sticky", int'(ovf), 1);
    strobe(1, 0, t);
    chk("R4 ovf cleared by line start", int'(ovf), 0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_overlap();
    t_unreached();
    t_saturate();
    t_stall();
    t_overflow();
    done = 1;
    summary();
  end
endmodule